// File: doc/BRIEF.md
# Queue Descriptor Masked Update Engine

This block owns a small bank of receive-queue descriptors and edits them on command. A command arrives as ten 32-bit words on a valid/ready stream, one word per accepted cycle. Once the tenth word is in, the block decodes it and checks it for legality. It then writes the chosen descriptor in a single cycle. Only the fields whose own update-enable bit is set are changed. The 128-bit packet number is replaced as one unit under a single enable. A separate bit zeroes the descriptor's statistics.

After the write the block can raise a one-cycle flush request for the descriptor it just changed. If the command asked for a reply, it also returns a status word carrying the command's tag.

A separate write port lets the reorder datapath store fresh statistics into any descriptor. A combinational read port exposes one descriptor's configuration, packet number and statistics.

Top module: `qdesc_update_engine`

## Requirements
- R1: Command words are taken one per cycle while `cmd_ready` is high. The descriptor is not modified until the tenth word has been accepted. `cmd_ready` is low in the cycle after the tenth word (apply) and in the flush cycle, if there is one.
- R2: The descriptor address is word 1 (bits 31:0) with word 2 bits 7:0 above it. Word 2 bits 8..29 are field enables, and each copies only its own field into the configuration image `{word4[27:0], word3}`. The enable-to-field mapping is:
  - bit 8: queue number, word3[15:0]
  - bit 9: valid, word3[16]
  - bit 10: link counter, word3[18:17]
  - bit 11: word3[19]
  - bit 12: word3[20]
  - bit 13: access category, word3[22:21]
  - bit 14: word3[23]
  - bit 15: word3[24]
  - bit 16: word3[25]
  - bit 17: word3[26]
  - bit 18: window size, word4[9:0]
  - bit 19: word3[27]
  - bit 20: word3[28]
  - bit 21: word3[29]
  - bit 22: word3[30]
  - bit 23: sequence-number size, word4[11:10]
  - bit 24: word3[31]
  - bit 25: word4[12]
  - bit 26: start sequence number, word4[24:13]
  - bit 27: word4[25]
  - bit 28: word4[26]
  - bit 29: word4[27]

  Every other bit keeps its old value.
- R3: Word 2 bit 30 replaces the whole 128-bit packet number with {word8, word7, word6, word5}, with word 5 least significant. When it is clear, the packet number is untouched.
- R4: Word 2 bit 31 sets the descriptor's whole statistics vector (timestamps, receive bitmap, counters) to zero in the apply cycle.
- R5: When word 4 bit 28 is set on a legal command, `flush_pulse` is high for exactly one cycle, the cycle after the apply cycle, with `flush_idx` naming the descriptor. Otherwise no flush is raised.
- R6: A command that enables the valid bit (word 2 bit 9) with word3[16]=0 and word 4 bit 28 clear is illegal.
- R7: A command that enables the sequence-number size with word4[11:10]=3 is illegal. The value 3 is harmless when its enable is clear.
- R8: A 40-bit address not below NUM_DESC is illegal. An illegal command writes nothing, clears nothing and flushes nothing.
- R9: The status word is produced only when word 0 bit 16 is set. `status_valid` is then high for one cycle, together with any flush. The status word is `status_data[15:0]` = word0[15:0], `status_data[16]` = 1 for illegal and 0 for success, and the upper bits are 0.
- R10: A datapath statistics write lands in the next cycle. If it targets the descriptor that a legal clearing command zeroes in the same cycle, the clear wins. A write to any other descriptor still lands.
- R11: After reset all descriptors read zero, `cmd_ready` is high, and `status_valid` and `flush_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_data | input | 32 | Command word |
| cmd_ready | output | 1 | Block can take a command word |
| status_valid | output | 1 | One-cycle status strobe |
| status_data | output | 32 | Tag and result code |
| flush_pulse | output | 1 | One-cycle flush request |
| flush_idx | output | IDX_W (2) | Descriptor to flush |
| stat_we | input | 1 | Datapath statistics write |
| stat_idx | input | IDX_W (2) | Descriptor for the statistics write |
| stat_data | input | 272 | New statistics vector |
| rd_idx | input | IDX_W (2) | Descriptor to read |
| rd_cfg | output | 60 | Configuration image of that descriptor |
| rd_pn | output | 128 | Packet number of that descriptor |
| rd_stat | output | 272 | Statistics vector of that descriptor |

## Verification
The functions that can fall in the same cycle are the command's statistics clear and a datapath statistics write. The bench holds `stat_we` high in the apply cycle of commands that target the same descriptor or a different one, and with and without the clear bit. It judges the outcome from `rd_stat` one cycle later: zero where the clear wins, the written vector otherwise. The same collision is driven under illegal commands, where the datapath write must land untouched. A near-exhaustive sweep takes every enable bit alone over every descriptor, and the result is compared against a mask model in the bench.

// File: rtl/qdu_pkg.sv
package qdu_pkg;
  localparam int CMD_WORDS = 10;
  localparam int WORD_W    = 32;
  localparam int CFG_W     = 60;
  localparam int PN_W      = 128;
  localparam int STAT_W    = 272;
  localparam int NUM_EN    = 23;
  localparam int EN_VALID  = 1;
  localparam int EN_PNSIZE = 15;
  localparam int EN_PN     = 22;

  typedef enum logic [1:0] {ST_COLLECT, ST_APPLY, ST_FLUSH} qdu_state_e;

  // which enable (word 2 bit 8+n) owns configuration image bit b
  function automatic int cfg_bit_owner(input int b);
    if (b <= 15) return 0;
    if (b == 16) return 1;
    if (b <= 18) return 2;
    if (b == 19) return 3;
    if (b == 20) return 4;
    if (b <= 22) return 5;
    if (b == 23) return 6;
    if (b == 24) return 7;
    if (b == 25) return 8;
    if (b == 26) return 9;
    if (b == 27) return 11;
    if (b == 28) return 12;
    if (b == 29) return 13;
    if (b == 30) return 14;
    if (b == 31) return 16;
    if (b <= 41) return 10;
    if (b <= 43) return 15;
    if (b == 44) return 17;
    if (b <= 56) return 18;
    if (b == 57) return 19;
    if (b == 58) return 20;
    return 21;
  endfunction
endpackage

// File: rtl/qdu_collect.sv
module qdu_collect #(
  parameter int WORDS = 10,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc,
  input  logic [DW-1:0]       din,
  output logic [WORDS*DW-1:0] words,
  output logic                last
);
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (acc) begin
      if (cnt_q == CNT_W'(WORDS - 1)) cnt_n = '0;
      else                            cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign last = acc && (cnt_q == CNT_W'(WORDS - 1));

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [DW-1:0] w_q;
    logic          w_en;
    assign w_en = acc && (cnt_q == CNT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    w_q <= '0;
      else if (w_en) w_q <= din;
    end
    assign words[i*DW +: DW] = w_q;
  end

  assert_count_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORDS - 1));
endmodule

// File: rtl/qdu_decode.sv
module qdu_decode
  import qdu_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int IDX_W    = 2
) (
  input  logic [CMD_WORDS*WORD_W-1:0] words,
  output logic [IDX_W-1:0]            idx,
  output logic                        legal,
  output logic [NUM_EN-1:0]           upd_en,
  output logic [CFG_W-1:0]            mask,
  output logic [CFG_W-1:0]            cfg_img,
  output logic [PN_W-1:0]             pn_img,
  output logic                        clr,
  output logic                        flush_req,
  output logic                        status_req,
  output logic [15:0]                 cmd_num
);
  logic [WORD_W-1:0] w0, w1, w2, w3, w4;
  logic [39:0]       addr;
  logic              addr_bad, valid_bad, size_bad;
  logic              unused_bits;

  assign w0 = words[0*WORD_W +: WORD_W];
  assign w1 = words[1*WORD_W +: WORD_W];
  assign w2 = words[2*WORD_W +: WORD_W];
  assign w3 = words[3*WORD_W +: WORD_W];
  assign w4 = words[4*WORD_W +: WORD_W];

  assign unused_bits = ^{w0[31:17], w4[31:29], words[9*WORD_W +: WORD_W]};

  assign addr       = {w2[7:0], w1};
  assign idx        = addr[IDX_W-1:0];
  assign upd_en     = w2[30:8];
  assign clr        = w2[31];
  assign flush_req  = w4[28];
  assign status_req = w0[16];
  assign cmd_num    = w0[15:0];
  assign cfg_img    = {w4[27:0], w3};
  assign pn_img     = words[5*WORD_W +: PN_W];

  for (genvar b = 0; b < CFG_W; b++) begin : g_mask
    localparam int OWNER = cfg_bit_owner(b);
    assign mask[b] = upd_en[OWNER];
  end

  assign addr_bad  = addr >= 40'(NUM_DESC);
  assign valid_bad = upd_en[EN_VALID] && !w3[16] && !w4[28];
  assign size_bad  = upd_en[EN_PNSIZE] && (w4[11:10] == 2'b11);
  assign legal     = !(addr_bad || valid_bad || size_bad);
endmodule

// File: rtl/qdu_store.sv
module qdu_store
  import qdu_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int IDX_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CFG_W-1:0]  wr_mask,
  input  logic [CFG_W-1:0]  wr_cfg,
  input  logic              wr_pn_en,
  input  logic [PN_W-1:0]   wr_pn,
  input  logic              wr_clr,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  logic [STAT_W-1:0] st_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CFG_W-1:0]  rd_cfg,
  output logic [PN_W-1:0]   rd_pn,
  output logic [STAT_W-1:0] rd_stat
);
  logic [CFG_W-1:0]  cfg_arr  [NUM_DESC];
  logic [PN_W-1:0]   pn_arr   [NUM_DESC];
  logic [STAT_W-1:0] stat_arr [NUM_DESC];

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_desc
    logic              sel, st_sel;
    logic [CFG_W-1:0]  cfg_q, cfg_n;
    logic [PN_W-1:0]   pn_q, pn_n;
    logic [STAT_W-1:0] st_q, st_n;

    assign sel    = wr_en && (wr_idx == IDX_W'(i));
    assign st_sel = st_we && (st_idx == IDX_W'(i));

    always_comb begin
      cfg_n = cfg_q;
      pn_n  = pn_q;
      st_n  = st_q;
      if (sel) begin
        cfg_n = (cfg_q & ~wr_mask) | (wr_cfg & wr_mask);
        if (wr_pn_en) pn_n = wr_pn;
      end
      if (sel && wr_clr) st_n = '0;
      else if (st_sel)   st_n = st_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
        pn_q  <= '0;
        st_q  <= '0;
      end else begin
        cfg_q <= cfg_n;
        pn_q  <= pn_n;
        st_q  <= st_n;
      end
    end

    assign cfg_arr[i]  = cfg_q;
    assign pn_arr[i]   = pn_q;
    assign stat_arr[i] = st_q;

    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr_clr) |=> (st_q == '0));
  end

  assign rd_cfg  = cfg_arr[rd_idx];
  assign rd_pn   = pn_arr[rd_idx];
  assign rd_stat = stat_arr[rd_idx];
endmodule

// File: rtl/qdesc_update_engine.sv
module qdesc_update_engine
  import qdu_pkg::*;
#(
  parameter int NUM_DESC = 4,
  localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [31:0]       cmd_data,
  output logic              cmd_ready,
  output logic              status_valid,
  output logic [31:0]       status_data,
  output logic              flush_pulse,
  output logic [IDX_W-1:0]  flush_idx,
  input  logic              stat_we,
  input  logic [IDX_W-1:0]  stat_idx,
  input  logic [STAT_W-1:0] stat_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CFG_W-1:0]  rd_cfg,
  output logic [PN_W-1:0]   rd_pn,
  output logic [STAT_W-1:0] rd_stat
);
  qdu_state_e state_q, state_n;

  logic [CMD_WORDS*WORD_W-1:0] words;
  logic                        acc, last;
  logic [IDX_W-1:0]            dec_idx;
  logic                        legal, clr, flush_req, status_req;
  logic [NUM_EN-1:0]           upd_en;
  logic [CFG_W-1:0]            mask, cfg_img;
  logic [PN_W-1:0]             pn_img;
  logic [15:0]                 cmd_num;
  logic                        apply, store_wr;
  logic                        sv_q, sv_n;
  logic [31:0]                 sd_q, sd_n;
  logic [IDX_W-1:0]            fidx_q, fidx_n;

  assign cmd_ready = (state_q == ST_COLLECT);
  assign acc       = cmd_valid && cmd_ready;
  assign apply     = (state_q == ST_APPLY);
  assign store_wr  = apply && legal;

  qdu_collect #(.WORDS(CMD_WORDS), .DW(WORD_W)) u_collect (
    .clk   (clk),
    .rst_n (rst_n),
    .acc   (acc),
    .din   (cmd_data),
    .words (words),
    .last  (last)
  );

  qdu_decode #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_decode (
    .words      (words),
    .idx        (dec_idx),
    .legal      (legal),
    .upd_en     (upd_en),
    .mask       (mask),
    .cfg_img    (cfg_img),
    .pn_img     (pn_img),
    .clr        (clr),
    .flush_req  (flush_req),
    .status_req (status_req),
    .cmd_num    (cmd_num)
  );

  qdu_store #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (store_wr),
    .wr_idx   (dec_idx),
    .wr_mask  (mask),
    .wr_cfg   (cfg_img),
    .wr_pn_en (upd_en[EN_PN]),
    .wr_pn    (pn_img),
    .wr_clr   (clr),
    .st_we    (stat_we),
    .st_idx   (stat_idx),
    .st_data  (stat_data),
    .rd_idx   (rd_idx),
    .rd_cfg   (rd_cfg),
    .rd_pn    (rd_pn),
    .rd_stat  (rd_stat)
  );

  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_COLLECT: if (last) state_n = ST_APPLY;
      ST_APPLY:   state_n = (flush_req && legal) ? ST_FLUSH : ST_COLLECT;
      default:    state_n = ST_COLLECT;
    endcase
  end

  always_comb begin
    sv_n   = 1'b0;
    sd_n   = sd_q;
    fidx_n = fidx_q;
    if (apply) begin
      sv_n   = status_req;
      sd_n   = {15'd0, !legal, cmd_num};
      fidx_n = dec_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      sv_q    <= 1'b0;
      sd_q    <= '0;
      fidx_q  <= '0;
    end else begin
      state_q <= state_n;
      sv_q    <= sv_n;
      sd_q    <= sd_n;
      fidx_q  <= fidx_n;
    end
  end

  assign status_valid = sv_q;
  assign status_data  = sv_q ? sd_q : 32'd0;
  assign flush_pulse  = (state_q == ST_FLUSH);
  assign flush_idx    = fidx_q;

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !cmd_ready);
  assert_flush_after_apply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> $past(apply));
  assert_flush_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |=> !flush_pulse);
  assert_pnsize_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (store_wr && upd_en[EN_PNSIZE]) |-> (cfg_img[43:42] != 2'b11));
  assert_status_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |=> !status_valid);
  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (store_wr && clr && rd_idx == dec_idx) |=> (!$stable(rd_idx) || rd_stat == '0));
endmodule

// File: tb/tb_qdesc_update_engine.sv
module tb_qdesc_update_engine;
  logic         clk, rst_n;
  logic         cmd_valid;
  logic [31:0]  cmd_data;
  logic         cmd_ready, status_valid, flush_pulse;
  logic [31:0]  status_data;
  logic [1:0]   flush_idx, stat_idx, rd_idx;
  logic         stat_we;
  logic [271:0] stat_data, rd_stat;
  logic [59:0]  rd_cfg;
  logic [127:0] rd_pn;

  qdesc_update_engine #(.NUM_DESC(4)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .status_valid(status_valid), .status_data(status_data),
    .flush_pulse(flush_pulse), .flush_idx(flush_idx), .stat_we(stat_we),
    .stat_idx(stat_idx), .stat_data(stat_data), .rd_idx(rd_idx),
    .rd_cfg(rd_cfg), .rd_pn(rd_pn), .rd_stat(rd_stat)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0]  cw [10];
  logic [59:0]  m_cfg [4];
  logic [127:0] m_pn [4];
  logic [271:0] m_st [4];

  task automatic chk(input string tag, input logic [271:0] act, input logic [271:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [59:0] bmask(input logic [22:0] e);
    logic [59:0] m;
    m = '0;
    m[15:0]  = {16{e[0]}};  m[16] = e[1];  m[18:17] = {2{e[2]}};
    m[19] = e[3];  m[20] = e[4];  m[22:21] = {2{e[5]}};
    m[23] = e[6];  m[24] = e[7];  m[25] = e[8];  m[26] = e[9];
    m[27] = e[11]; m[28] = e[12]; m[29] = e[13]; m[30] = e[14]; m[31] = e[16];
    m[41:32] = {10{e[10]}}; m[43:42] = {2{e[15]}}; m[44] = e[17];
    m[56:45] = {12{e[18]}}; m[57] = e[19]; m[58] = e[20]; m[59] = e[21];
    return m;
  endfunction

  task automatic stat_put(input logic [1:0] idx, input logic [271:0] d);
    @(negedge clk);
    stat_we = 1'b1; stat_idx = idx; stat_data = d;
    @(negedge clk);
    stat_we = 1'b0;
    m_st[idx] = d;
    rd_idx = idx; #1;
    chk("R10 datapath stat write", rd_stat, m_st[idx]);
  endtask

  task automatic run_cmd(input bit cl_en, input logic [1:0] cl_idx, input logic [271:0] cl_dat);
    logic [39:0] addr;
    logic [22:0] en;
    logic [1:0]  t;
    bit oor, fl, err, clr, sreq;
    addr = {cw[2][7:0], cw[1]};
    t    = cw[1][1:0];
    en   = cw[2][30:8];
    clr  = cw[2][31];
    fl   = cw[4][28];
    sreq = cw[0][16];
    oor  = addr >= 40'd4;
    err  = oor || (en[1] && !cw[3][16] && !fl) || (en[15] && cw[4][11:10] == 2'b11);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 9) begin
        rd_idx = t; #1;
        chk("R1 unchanged before last word", {rd_cfg, rd_pn}, {m_cfg[t], m_pn[t]});
        chk("R1 ready while collecting", cmd_ready, 1'b1);
      end
      cmd_valid = 1'b1; cmd_data = cw[i];
      @(posedge clk);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R1 ready low in apply", cmd_ready, 1'b0);
    if (cl_en) begin stat_we = 1'b1; stat_idx = cl_idx; stat_data = cl_dat; end
    @(negedge clk);
    stat_we = 1'b0;
    if (cl_en) m_st[cl_idx] = cl_dat;
    if (!err) begin
      m_cfg[t] = (m_cfg[t] & ~bmask(en)) | ({cw[4][27:0], cw[3]} & bmask(en));
      if (en[22]) m_pn[t] = {cw[8], cw[7], cw[6], cw[5]};
      if (clr) m_st[t] = '0;
    end
    chk("R9 status strobe", status_valid, sreq);
    if (sreq) chk("R9 status word R6 R7 R8", status_data, {15'd0, err, cw[0][15:0]});
    chk("R5 flush pulse", flush_pulse, fl && !err);
    if (fl && !err) chk("R5 flush index", flush_idx, t);
    if (!fl || err) chk("R5 ready low only with flush", cmd_ready, 1'b1);
    rd_idx = t; #1;
    chk("R2 cfg image", rd_cfg, m_cfg[t]);
    chk("R3 packet number", rd_pn, m_pn[t]);
    chk("R4 stats", rd_stat, m_st[t]);
    if (cl_en) begin
      rd_idx = cl_idx; #1;
      chk("R10 clash stats", rd_stat, m_st[cl_idx]);
    end
    @(negedge clk);
    chk("R5 R9 quiet after", {cmd_ready, status_valid, flush_pulse}, 3'b100);
  endtask

  task automatic build(input logic [15:0] num, input bit sreq, input logic [39:0] addr,
                       input logic [22:0] en, input bit clr, input logic [31:0] w3,
                       input logic [31:0] w4, input logic [127:0] pn);
    cw[0] = {15'd0, sreq, num};
    cw[1] = addr[31:0];
    cw[2] = {clr, en, addr[39:32]};
    cw[3] = w3;
    cw[4] = w4;
    cw[5] = pn[31:0]; cw[6] = pn[63:32]; cw[7] = pn[95:64]; cw[8] = pn[127:96];
    cw[9] = 32'hDEAD_BEEF;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cmd_valid = 0; cmd_data = '0; stat_we = 0; stat_idx = '0; stat_data = '0; rd_idx = '0;
    rst_n = 0;
    for (int d = 0; d < 4; d++) begin m_cfg[d] = '0; m_pn[d] = '0; m_st[d] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset outputs", {cmd_ready, status_valid, flush_pulse}, 3'b100);
    for (int d = 0; d < 4; d++) begin
      rd_idx = 2'(d); #1;
      chk("R11 reset descriptor", {rd_cfg, rd_pn, rd_stat} == '0, 1'b1);
    end

    for (int d = 0; d < 4; d++)
      stat_put(2'(d), {17{16'hC000 + 16'(d * 16'h0111)}});

    // sweep: each enable alone on each descriptor
    for (int t = 0; t < 4; t++) begin
      for (int k = 0; k < 23; k++) begin
        int s;
        s = t * 23 + k;
        build(16'(16'h0100 + s), (s % 3) != 0, 40'(t), 23'(1) << k, 1'b0,
              32'h9E37_79B9 * 32'(s + 1), 32'h7F4A_7C15 * 32'(s + 3),
              {32'h1111_0000 + 32'(s), 32'hA5A5_0000 ^ 32'(s * 7),
               32'h0F0F_1234 * 32'(s + 5), 32'h5555_AAAA + 32'(s)});
        run_cmd(1'b0, 2'd0, '0);
      end
    end

    // all enables, clear, flush, status (R2 R3 R4 R5)
    build(16'hBEEF, 1'b1, 40'd2, '1, 1'b1, 32'hFFFF_FFFF, 32'h1FFF_F3FF,
          128'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF);
    run_cmd(1'b0, 2'd0, '0);
    // valid to 0 without flush: illegal (R6)
    build(16'h0601, 1'b1, 40'd2, 23'(1) << 1, 1'b1, 32'h0, 32'h0, '0);
    run_cmd(1'b0, 2'd0, '0);
    // valid to 0 with flush: legal, flush raised (R6 R5)
    build(16'h0602, 1'b1, 40'd2, 23'(1) << 1, 1'b0, 32'h0, 32'h1000_0000, '0);
    run_cmd(1'b0, 2'd0, '0);
    // size 3 with enable: illegal (R7)
    build(16'h0701, 1'b1, 40'd1, (23'(1) << 15) | 23'h1, 1'b0, 32'h1234_5678, 32'h0000_0C00, '0);
    run_cmd(1'b0, 2'd0, '0);
    // size 3 without its enable: legal (R7)
    build(16'h0702, 1'b1, 40'd1, 23'h1, 1'b0, 32'h0000_4321, 32'h0000_0C00, '0);
    run_cmd(1'b0, 2'd0, '0);
    // out of range addresses (R8), with a clash that must still land
    build(16'h0801, 1'b1, 40'd4, '1, 1'b1, 32'hFFFF_FFFF, 32'h1FFF_FFFF, '1);
    run_cmd(1'b1, 2'd0, {17{16'h7777}});
    build(16'h0802, 1'b1, 40'h80_0000_0003, '1, 1'b1, 32'hFFFF_FFFF, 32'h1FFF_FFFF, '1);
    run_cmd(1'b1, 2'd3, {17{16'h6666}});
    // collisions (R10)
    stat_put(2'd1, {17{16'h1357}});
    build(16'h0A01, 1'b0, 40'd1, '0, 1'b1, 32'h0, 32'h0, '0);
    run_cmd(1'b1, 2'd1, {17{16'h2468}});
    build(16'h0A02, 1'b1, 40'd1, '0, 1'b1, 32'h0, 32'h1000_0000, '0);
    run_cmd(1'b1, 2'd2, {17{16'h9ABC}});
    build(16'h0A03, 1'b1, 40'd3, 23'h1, 1'b0, 32'h0000_00AA, 32'h0, '0);
    run_cmd(1'b1, 2'd3, {17{16'hDEF0}});
    // final readback of all descriptors
    for (int d = 0; d < 4; d++) begin
      rd_idx = 2'(d); #1;
      chk("R2 R3 R4 final image", {rd_cfg, rd_pn, rd_stat}, {m_cfg[d], m_pn[d], m_st[d]});
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule